// File: doc/BRIEF.md
# Raster Timing Generator for a 256 by 256 Bit-Mapped Display

This block produces every timing signal for a monochrome bit-mapped picture of 256 dots on each of 256 visible lines, inside a 262-line frame at a 60 Hz field rate. It runs from a clock at twice the dot rate. An internal phase toggle divides that clock down to the dot rate. Three counters drive the picture. A bit counter selects the dot within a byte. A slot state machine walks the 46 byte slots of a line. A line counter tracks the raster row.

The block asks display memory for each byte one slot before that byte is shown. It sends out a fetch request and a 13-bit byte address, and it takes the byte returned on the same dot. Returned bytes go alternately into two shift registers. Each register sends its byte out with the most significant bit first. The block also makes the sync signals, the retrace flags and the gated dot video.

The slot machine has four states. SYNC covers slots 0 to 2. LEFT covers slots 3 to 7. DATA covers slots 8 to 39. RIGHT covers slots 40 to 45. Each state moves to the next on the last dot of its last slot: SYNC to LEFT, LEFT to DATA, DATA to RIGHT, and RIGHT to SYNC. The RIGHT to SYNC transition marks the end of the line.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is high and on the first clock after it, all of the following hold: hsync, vsync, csync, video and fetch_req are 0, hretrace is 1 and vretrace is 0.
- R2: A dot lasts 2 clocks. A line is 46 slots of 8 dots, which is 736 clocks. Counting slots from 0 at reset, hretrace is 0 only in slots 8 to 39.
- R3: A frame has 262 lines. The line number advances by one at the end of each line and returns to 0 after line 261. It appears as fetch_addr[12:5].
- R4: hsync goes high on the clock edge that ends a line and stays high for 58 clocks, which is about 5 µs. It never goes high before the first line has ended.
- R5: vsync and vretrace are high exactly on lines 256 to 261.
- R6: On lines 0 to 255, fetch_req is high during the last dot of slots 7 to 38. During that dot, fetch_addr[4:0] equals the slot number minus 7, so it is one byte ahead of the picture.
- R7: The byte taken with a fetch is shown in the next slot, bit 7 first, one bit per dot. Consecutive bytes use the two shift registers in turn. With graphics enabled and no other control set, video equals the current pixel inside slots 8 to 39 of lines 0 to 255, and video is 0 everywhere else.
- R8: csync equals hsync exclusive-or vsync, so the sync is serrated during vertical retrace.
- R9: With gfx_en low, all pixels read as 0. With invert high, video is inverted inside the picture window only, and the margins and retrace stay 0.
- R10: blank high forces video to 0 whatever the other controls are.
- R11: With dots_mode high, video is also ANDed with the dot phase. That phase is low in the first clock of each dot and high in the second, so video can be 1 only on odd clock counts after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the dot rate |
| rst | input | 1 | Synchronous reset, active high |
| gfx_en | input | 1 | Enables bitmap pixels into the video |
| invert | input | 1 | Inverts video inside the picture window |
| blank | input | 1 | Forces video to 0 |
| dots_mode | input | 1 | ANDs the dot phase into the video |
| fetch_data | input | 8 | Byte returned by display memory for the current fetch |
| fetch_req | output | 1 | Display memory fetch request |
| fetch_addr | output | 13 | Byte address: line in bits 12..5, byte index in bits 4..0 |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| csync | output | 1 | Serrated composite sync |
| video | output | 1 | Dot video |
| hretrace | output | 1 | High outside the 32 data slots |
| vretrace | output | 1 | High on lines 256 to 261 |

## Verification
A slot counter that is off by one shows up within one line. The fetch address low bits and the edges of hretrace shift against the clock count, and every pixel moves sideways. A shift register selected wrongly or loaded out of turn shows up on the next data byte, as wrong dots on a known address pattern. A line counter that wraps at the wrong point shows up only at the bottom of the frame, as a vsync edge on the wrong line. A wrong wrap back to line 0 shows up as a wrong line field in the first fetch of the next frame. For these reasons the bench compares every output on every clock across one full frame and into the next, including the line-wrap point.

// File: rtl/raster_pkg.sv
package raster_pkg;
    typedef enum logic [1:0] {
        HP_SYNC  = 2'd0,
        HP_LEFT  = 2'd1,
        HP_DATA  = 2'd2,
        HP_RIGHT = 2'd3
    } hphase_t;
endpackage

// File: rtl/raster_hcount.sv
module raster_hcount
    import raster_pkg::*;
#(
    parameter int SYNC_B  = 3,
    parameter int LEFT_B  = 5,
    parameter int DATA_B  = 32,
    parameter int RIGHT_B = 6,
    parameter int PC_W    = $clog2(DATA_B + 1)
) (
    input  logic            clk,
    input  logic            rst,
    output logic            dot_ph,
    output logic [2:0]      hbit,
    output hphase_t         phase,
    output logic [PC_W-1:0] pcnt,
    output logic            slot_end,
    output logic            phase_last,
    output logic            eol
);
    localparam logic [PC_W-1:0] SYNC_LAST  = PC_W'(SYNC_B - 1);
    localparam logic [PC_W-1:0] LEFT_LAST  = PC_W'(LEFT_B - 1);
    localparam logic [PC_W-1:0] DATA_LAST  = PC_W'(DATA_B - 1);
    localparam logic [PC_W-1:0] RIGHT_LAST = PC_W'(RIGHT_B - 1);

    hphase_t         phase_nxt;
    logic [PC_W-1:0] last_idx;

    // output / next-state logic
    always_comb begin
        unique case (phase)
            HP_SYNC:  begin last_idx = SYNC_LAST;  phase_nxt = HP_LEFT;  end
            HP_LEFT:  begin last_idx = LEFT_LAST;  phase_nxt = HP_DATA;  end
            HP_DATA:  begin last_idx = DATA_LAST;  phase_nxt = HP_RIGHT; end
            HP_RIGHT: begin last_idx = RIGHT_LAST; phase_nxt = HP_SYNC;  end
            default:  begin last_idx = SYNC_LAST;  phase_nxt = HP_SYNC;  end
        endcase
        phase_last = (pcnt == last_idx);
        slot_end   = dot_ph && (hbit == 3'd7);
        eol        = slot_end && phase_last && (phase == HP_RIGHT);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            dot_ph <= 1'b0;
            hbit   <= 3'd0;
            phase  <= HP_SYNC;
            pcnt   <= '0;
        end else begin
            dot_ph <= ~dot_ph;
            if (dot_ph) hbit <= hbit + 3'd1;
            if (slot_end) begin
                if (phase_last) begin
                    phase <= phase_nxt;
                    pcnt  <= '0;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end
        end
    end

    a_r2_wrap_to_sync: assert property (@(posedge clk) disable iff (rst)
        eol |=> (phase == HP_SYNC && pcnt == '0 && hbit == 3'd0));
    a_r2_dot_pace: assert property (@(posedge clk) disable iff (rst)
        !$past(dot_ph) |-> $stable(hbit));
endmodule

// File: rtl/raster_vcount.sv
module raster_vcount #(
    parameter int LINES  = 262,
    parameter int ACT_W  = 8,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eol,
    output logic [LINE_W-1:0] line,
    output logic              vret
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

    always_ff @(posedge clk) begin
        if (rst)
            line <= '0;
        else if (eol)
            line <= (line == LAST_LINE) ? '0 : line + 1'b1;
    end

    assign vret = line[ACT_W];

    a_r3_line_step: assert property (@(posedge clk) disable iff (rst)
        eol |=> (line == (($past(line) == LAST_LINE) ? '0 : $past(line) + 1'b1)));
endmodule

// File: rtl/raster_serializer.sv
module raster_serializer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         sel,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         pix
);
    logic [W-1:0] sreg [2];
    logic [1:0]   load_vec;
    logic         show_sel;

    generate
        for (genvar i = 0; i < 2; i++) begin : g_sr
            assign load_vec[i] = load && (sel == 1'(i));
            always_ff @(posedge clk) begin
                if (rst)
                    sreg[i] <= '0;
                else if (load_vec[i])
                    sreg[i] <= din;
                else if (shift && show_sel == 1'(i))
                    sreg[i] <= {sreg[i][W-2:0], 1'b0};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            show_sel <= 1'b1;
        else if (load)
            show_sel <= sel;
    end

    assign pix = sreg[show_sel][W-1];

    a_r7_alternate: assert property (@(posedge clk) disable iff (rst)
        load |-> (sel != show_sel));
    a_r7_single_load: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_vec));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int SYNC_B  = 3,
    parameter int LEFT_B  = 5,
    parameter int DATA_B  = 32,
    parameter int RIGHT_B = 6,
    parameter int LINES   = 262,
    parameter int ACT_W   = 8,
    parameter int HS_CLKS = 58
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     gfx_en,
    input  logic                     invert,
    input  logic                     blank,
    input  logic                     dots_mode,
    input  logic [7:0]               fetch_data,
    output logic                     fetch_req,
    output logic [ACT_W+$clog2(DATA_B)-1:0] fetch_addr,
    output logic                     hsync,
    output logic                     vsync,
    output logic                     csync,
    output logic                     video,
    output logic                     hretrace,
    output logic                     vretrace
);
    localparam int PC_W   = $clog2(DATA_B + 1);
    localparam int BYTE_W = $clog2(DATA_B);
    localparam int LINE_W = $clog2(LINES);
    localparam int HS_W   = $clog2(HS_CLKS + 1);

    logic              dot_ph, slot_end, phase_last, eol, pix;
    logic [2:0]        hbit;
    hphase_t           phase;
    logic [PC_W-1:0]   pcnt;
    logic [LINE_W-1:0] line;
    logic [BYTE_W-1:0] byte_ctr;
    logic [HS_W-1:0]   hs_cnt;
    logic              fetch_slot, window, v_pic;

    raster_hcount #(
        .SYNC_B(SYNC_B), .LEFT_B(LEFT_B), .DATA_B(DATA_B), .RIGHT_B(RIGHT_B), .PC_W(PC_W)
    ) u_h (
        .clk(clk), .rst(rst), .dot_ph(dot_ph), .hbit(hbit), .phase(phase),
        .pcnt(pcnt), .slot_end(slot_end), .phase_last(phase_last), .eol(eol)
    );

    raster_vcount #(.LINES(LINES), .ACT_W(ACT_W), .LINE_W(LINE_W)) u_v (
        .clk(clk), .rst(rst), .eol(eol), .line(line), .vret(vretrace)
    );

    raster_serializer #(.W(8)) u_s (
        .clk(clk), .rst(rst),
        .load(fetch_req && slot_end), .sel(byte_ctr[0]), .din(fetch_data),
        .shift(dot_ph && phase == HP_DATA), .pix(pix)
    );

    // byte counter: one byte ahead of the picture
    always_ff @(posedge clk) begin
        if (rst || eol)
            byte_ctr <= '0;
        else if (fetch_req && slot_end)
            byte_ctr <= byte_ctr + 1'b1;
    end

    // horizontal sync one-shot
    always_ff @(posedge clk) begin
        if (rst)
            hs_cnt <= '0;
        else if (eol)
            hs_cnt <= HS_W'(HS_CLKS);
        else if (hs_cnt != '0)
            hs_cnt <= hs_cnt - 1'b1;
    end

    always_comb begin
        fetch_slot = (phase == HP_LEFT && phase_last) || (phase == HP_DATA && !phase_last);
        fetch_req  = fetch_slot && (hbit == 3'd7) && !vretrace;
        fetch_addr = {line[ACT_W-1:0], byte_ctr};
        hsync      = (hs_cnt != '0);
        vsync      = vretrace;
        csync      = hsync ^ vsync;
        hretrace   = (phase != HP_DATA);
        window     = (phase == HP_DATA) && !vretrace;
        v_pic      = window && ((gfx_en && pix) ^ invert);
        video      = v_pic && !blank && (!dots_mode || dot_ph);
    end

    a_r4_hs_start: assert property (@(posedge clk) disable iff (rst)
        eol |=> hsync);
    a_r5_vs_begin: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync) |-> (phase == HP_SYNC && hbit == 3'd0));
    a_r6_first_fetch: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && phase == HP_LEFT) |-> (fetch_addr[BYTE_W-1:0] == '0));
    a_r8_serrated: assert property (@(posedge clk) disable iff (rst)
        vsync |-> (csync != hsync));
endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gfx_en = 1'b1, invert = 1'b0, blank = 1'b0, dots_mode = 1'b0;
    logic [7:0]  fetch_data;
    logic        fetch_req, hsync, vsync, csync, video, hretrace, vretrace;
    logic [12:0] fetch_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    raster_timing_gen u0 (
        .clk(clk), .rst(rst), .gfx_en(gfx_en), .invert(invert), .blank(blank),
        .dots_mode(dots_mode), .fetch_data(fetch_data), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .hsync(hsync), .vsync(vsync), .csync(csync),
        .video(video), .hretrace(hretrace), .vretrace(vretrace)
    );

    function automatic logic [7:0] pat(input logic [12:0] a);
        return (8'(a[4:0]) * 8'd37) ^ a[12:5] ^ 8'h5A;
    endfunction

    assign fetch_data = pat(fetch_addr);

    typedef struct packed {
        logic [8:0] from_line;
        logic       g, i, b, d;
    } ctrl_t;

    // control vectors applied from a line onward (first frame)
    localparam ctrl_t TBL [7] = '{
        '{9'd0,  1'b1, 1'b0, 1'b0, 1'b0},   // plain picture, R7
        '{9'd3,  1'b1, 1'b1, 1'b0, 1'b0},   // inverted, R9
        '{9'd5,  1'b1, 1'b0, 1'b0, 1'b1},   // dots, R11
        '{9'd7,  1'b0, 1'b0, 1'b0, 1'b0},   // graphics off, R9
        '{9'd9,  1'b1, 1'b1, 1'b1, 1'b1},   // blanked, R10
        '{9'd11, 1'b0, 1'b1, 1'b0, 1'b0},   // off and inverted, R9
        '{9'd13, 1'b1, 1'b0, 1'b0, 1'b0}    // plain to frame end, R7
    };

    task automatic chk(input string tag, input int act, input int exp, input int n);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s clk %0d actual %0d expected %0d", tag, n, act, exp);
        end
    endtask

    function automatic string vtag(input int idx);
        case (idx)
            1, 3, 5: return "R9";
            2:       return "R11";
            4:       return "R10";
            default: return "R7";
        endcase
    endfunction

    localparam int FRAME = 736 * 262;
    localparam int NEND  = FRAME + 736 * 2;

    initial begin
        int n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        chk("R1 hsync", int'(hsync), 0, 0);
        chk("R1 vsync", int'(vsync), 0, 0);
        chk("R1 fetch_req", int'(fetch_req), 0, 0);
        chk("R1 hretrace", int'(hretrace), 1, 0);
        rst = 1'b0;
        while (n < NEND) begin
            int dot, slot, bt, line, idx, hs, vs, fr, v, px;
            logic [7:0] by;
            @(posedge clk);
            n++;
            @(negedge clk);
            dot  = n / 2;
            slot = (dot / 8) % 46;
            bt   = dot % 8;
            line = (dot / 368) % 262;
            idx  = 0;
            if (n < FRAME)
                for (int k = 0; k < 7; k++)
                    if (line >= int'(TBL[k].from_line)) idx = k;
            gfx_en = TBL[idx].g; invert = TBL[idx].i;
            blank = TBL[idx].b; dots_mode = TBL[idx].d;
            #1;
            if (n == 1) begin
                chk("R1 video", int'(video), 0, n);
                chk("R1 csync", int'(csync), 0, n);
                chk("R1 vretrace", int'(vretrace), 0, n);
            end
            chk("R2 hretrace", int'(hretrace), (slot >= 8 && slot <= 39) ? 0 : 1, n);
            hs = (n >= 736 && (n % 736) < 58) ? 1 : 0;
            vs = (line >= 256) ? 1 : 0;
            chk("R4 hsync", int'(hsync), hs, n);
            chk("R5 vsync", int'(vsync), vs, n);
            chk("R5 vretrace", int'(vretrace), vs, n);
            chk("R8 csync", int'(csync), hs ^ vs, n);
            fr = (bt == 7 && slot >= 7 && slot <= 38 && line < 256) ? 1 : 0;
            chk("R6 fetch_req", int'(fetch_req), fr, n);
            if (fr == 1) begin
                chk("R6 byte index", int'(fetch_addr[4:0]), slot - 7, n);
                chk("R3 line field", int'(fetch_addr[12:5]), line, n);
            end
            v = 0;
            if (slot >= 8 && slot <= 39 && line < 256) begin
                by = pat({line[7:0], 5'(slot - 8)});
                px = int'(by[7 - bt]);
                v  = (int'(TBL[idx].g) & px) ^ int'(TBL[idx].i);
            end
            if (TBL[idx].b) v = 0;
            if (TBL[idx].d && (n % 2) == 0) v = 0;
            chk(vtag(idx), int'(video), v, n);
        end
        // R1: reset in mid-line returns to the start state
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 hsync mid", int'(hsync), 0, n);
        chk("R1 vsync mid", int'(vsync), 0, n);
        chk("R1 video mid", int'(video), 0, n);
        chk("R1 fetch mid", int'(fetch_req), 0, n);
        chk("R1 hretrace mid", int'(hretrace), 1, n);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule